// File: doc/BRIEF.md
# Round-Robin Task Flow Fault Monitor

This block sits beside a processor and listens, without ever driving anything, to its instruction-fetch address and to the periodic scheduler tick of a real-time kernel. Each valid fetch address is compared against a table of per-task address ranges, held on input ports, to find out which task is running. Fetches from addresses outside every range, such as kernel code, leave the running task unchanged.

The monitor holds its own copy of a round-robin schedule (task 0, then 1, then 2, then back to 0). Each tick opens a switch window of `TCS_CYC` cycles. A task change inside that window must go to the next task in the round-robin order. If no change happens within `TL_CYC` cycles of the tick, the time limit has been missed. A task change outside any window means a context switch happened between ticks. Sequence faults and timing faults are reported on separate outputs. Each kind has a one-cycle pulse and a flag that stays set until it is cleared.

Top module: `task_flow_monitor`

## Requirements
- R1: Task i (numbered from 0) matches when `range_lo[i*ADDR_W +: ADDR_W] <= addr <= range_hi[i*ADDR_W +: ADDR_W]` and `addr_valid` is high. When several ranges match, the lowest index wins. `cur_task` takes the matched ID on the clock edge that samples the fetch.
- R2: A fetch that matches no range, or any address while `addr_valid` is low, leaves `cur_task` unchanged and is not treated as a task switch.
- R3: After reset, `task_known`, `cur_task`, both pulses and both flags are 0. The first matching fetch loads `cur_task` and sets `task_known`. No error pulse occurs while `task_known` is low, and ticks are ignored until it is high.
- R4: Elapsed time counts 0 in the tick cycle and rises by one each following cycle. A switch at an elapsed time below `TCS_CYC` to the expected task raises no error. The expected task is `cur_task+1`, wrapping from `N_TASKS-1` to 0.
- R5: A switch inside the window to any task other than the expected one gives one `seq_err_pulse`, with no time error.
- R6: If no switch has happened by elapsed time `TL_CYC-1`, one `seq_err_pulse` follows and the window closes. The expected order then restarts from the observed task.
- R7: A switch while no window is open gives one `time_err_pulse` and no sequence error. This covers a switch with no tick since the previous switch, a switch at an elapsed time of `TCS_CYC` or more, and a switch after the time limit has expired.
- R8: Each pulse is high for one cycle, in the cycle after the fault. The matching flag is set in that same cycle and stays set until `err_clear` is sampled high. A new fault in the same cycle as `err_clear` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Observed instruction fetch address |
| addr_valid | input | 1 | Fetch address is valid this cycle |
| tick | input | 1 | Scheduler tick, marks a permitted switch point |
| err_clear | input | 1 | Clears both sticky flags |
| range_lo | input | N_TASKS*ADDR_W | Per-task lowest address, task i in slice i |
| range_hi | input | N_TASKS*ADDR_W | Per-task highest address, task i in slice i |
| cur_task | output | TID_W | Currently detected task ID |
| task_known | output | 1 | A task has been identified since reset |
| seq_err_pulse | output | 1 | One-cycle sequence fault indication |
| time_err_pulse | output | 1 | One-cycle timing fault indication |
| seq_err_flag | output | 1 | Sticky sequence fault flag |
| time_err_flag | output | 1 | Sticky timing fault flag |

## Verification
Two collisions matter most. The first is a tick and a task switch landing in the same cycle. The bench provokes it by driving the tick together with the new task's address, and the switch must be judged as inside the window, at elapsed time 0. The second is `err_clear` arriving in the same cycle as a new timing fault. The bench drives an untimed switch together with the clear, and the flag must read as set afterwards. A sweep over every pair of old and new tasks and every switch delay from 0 to `TL_CYC+1` checks the pulse counts against values worked out from the window and time-limit rules.

// File: rtl/task_flow_monitor.sv
module task_flow_monitor #(
  parameter int ADDR_W  = 16,
  parameter int N_TASKS = 3,
  parameter int TCS_CYC = 8,
  parameter int TL_CYC  = 64,
  localparam int TID_W  = $clog2(N_TASKS),
  localparam int CNT_W  = $clog2(TL_CYC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      addr_valid,
  input  logic                      tick,
  input  logic                      err_clear,
  input  logic [N_TASKS*ADDR_W-1:0] range_lo,
  input  logic [N_TASKS*ADDR_W-1:0] range_hi,
  output logic [TID_W-1:0]          cur_task,
  output logic                      task_known,
  output logic                      seq_err_pulse,
  output logic                      time_err_pulse,
  output logic                      seq_err_flag,
  output logic                      time_err_flag
);

  logic [N_TASKS-1:0] hit;
  logic [TID_W-1:0]   hit_tid, exp_tid;
  logic [CNT_W-1:0]   cnt, elapsed;
  logic               armed, any_hit, switch_ev, open, in_win, timeout, seq_ev, time_ev;

  for (genvar i = 0; i < N_TASKS; i++) begin : g_match
    assign hit[i] = addr >= range_lo[i*ADDR_W +: ADDR_W] &&
                    addr <= range_hi[i*ADDR_W +: ADDR_W];
  end

  always_comb begin
    hit_tid = '0;
    for (int i = N_TASKS - 1; i >= 0; i--)
      if (hit[i]) hit_tid = TID_W'(i);
  end

  assign any_hit   = addr_valid && |hit;
  assign exp_tid   = (cur_task == TID_W'(N_TASKS - 1)) ? '0 : cur_task + 1'b1;
  assign switch_ev = task_known && any_hit && hit_tid != cur_task;
  assign elapsed   = tick ? '0 : cnt;
  assign open      = task_known && (tick || armed);
  assign in_win    = open && elapsed < CNT_W'(TCS_CYC);
  assign timeout   = open && !switch_ev && elapsed == CNT_W'(TL_CYC - 1);
  assign seq_ev    = (switch_ev && in_win && hit_tid != exp_tid) || timeout;
  assign time_ev   = switch_ev && !in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_task       <= '0;
      task_known     <= 1'b0;
      armed          <= 1'b0;
      cnt            <= '0;
      seq_err_pulse  <= 1'b0;
      time_err_pulse <= 1'b0;
      seq_err_flag   <= 1'b0;
      time_err_flag  <= 1'b0;
    end else begin
      if (any_hit) cur_task <= hit_tid;
      task_known <= task_known | any_hit;
      if (task_known && tick && !switch_ev) begin
        armed <= 1'b1;
        cnt   <= CNT_W'(1);
      end else if (switch_ev || timeout) begin
        armed <= 1'b0;
      end else if (armed) begin
        cnt <= cnt + 1'b1;
      end
      seq_err_pulse  <= seq_ev;
      time_err_pulse <= time_ev;
      seq_err_flag   <= (seq_err_flag & ~err_clear) | seq_ev;
      time_err_flag  <= (time_err_flag & ~err_clear) | time_ev;
    end
  end

  p_quiet_until_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !task_known |-> !seq_err_pulse && !time_err_pulse);

  p_unmatched_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    task_known && !(addr_valid && |hit) |=> $stable(cur_task));

  p_clean_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    task_known && any_hit && tick && hit_tid == exp_tid && hit_tid != cur_task
    |=> !seq_err_pulse && !time_err_pulse);

  p_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_err_pulse && time_err_pulse));

  p_late_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    task_known && any_hit && hit_tid != cur_task && !tick && !armed |=> time_err_pulse);

  p_pulse_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err_pulse |-> seq_err_flag) and (time_err_pulse |-> time_err_flag));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_flag && !err_clear |=> seq_err_flag);

endmodule

// File: tb/tb_task_flow_monitor.sv
module tb_task_flow_monitor;
  localparam int AW = 8, NT = 3, TCS = 4, TL = 10;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic addr_valid = 0, tick = 0, err_clear = 0;
  logic [NT*AW-1:0] range_lo, range_hi;
  logic [1:0] cur_task;
  logic task_known, seq_err_pulse, time_err_pulse, seq_err_flag, time_err_flag;

  int checks = 0, fails = 0, seq_cnt = 0, time_cnt = 0;

  always #4 clk = ~clk;

  task_flow_monitor #(.ADDR_W(AW), .N_TASKS(NT), .TCS_CYC(TCS), .TL_CYC(TL)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_valid(addr_valid), .tick(tick),
    .err_clear(err_clear), .range_lo(range_lo), .range_hi(range_hi),
    .cur_task(cur_task), .task_known(task_known), .seq_err_pulse(seq_err_pulse),
    .time_err_pulse(time_err_pulse), .seq_err_flag(seq_err_flag), .time_err_flag(time_err_flag));

  function automatic logic [AW-1:0] ta(int i);
    return AW'(16 * (i + 1) + 3);
  endfunction

  task automatic set_ranges(logic [AW-1:0] hi0);
    range_lo = {8'h30, 8'h20, 8'h10};
    range_hi = {8'h3F, 8'h2F, hi0};
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [AW-1:0] a, logic v, logic t, logic c);
    @(negedge clk);
    addr = a; addr_valid = v; tick = t; err_clear = c;
    @(posedge clk); #1;
    seq_cnt  += int'(seq_err_pulse);
    time_cnt += int'(time_err_pulse);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; addr_valid = 0; tick = 0; err_clear = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    seq_cnt = 0; time_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_ranges(8'h1F);
    do_reset();
    #1;
    chk("R3 reset task_known", int'(task_known), 0);
    chk("R3 reset cur_task", int'(cur_task), 0);
    chk("R3 reset flags", int'(seq_err_flag) + int'(time_err_flag), 0);
    chk("R3 reset pulses", int'(seq_err_pulse) + int'(time_err_pulse), 0);

    step(8'h80, 1, 1, 0);
    step(8'h80, 1, 0, 0);
    step(ta(1), 0, 1, 0);
    chk("R3 unknown before match", int'(task_known), 0);
    chk("R3 no pulses before match", seq_cnt + time_cnt, 0);
    step(ta(2), 1, 0, 0);
    chk("R3 first match known", int'(task_known), 1);
    chk("R1 first match id", int'(cur_task), 2);
    chk("R3 first match no error", seq_cnt + time_cnt, 0);

    step(8'h80, 1, 0, 0);
    step(ta(0), 0, 0, 0);
    step(8'h05, 1, 0, 0);
    chk("R2 cur_task held", int'(cur_task), 2);
    chk("R2 no switch seen", seq_cnt + time_cnt, 0);

    set_ranges(8'h2F);
    step(8'h23, 1, 1, 0);
    chk("R1 overlap lowest index", int'(cur_task), 0);
    chk("R4 wrap 2 to 0 at tick", seq_cnt + time_cnt, 0);
    set_ranges(8'h1F);
    step(8'h80, 1, 0, 0);

    for (int c = 0; c < NT; c++)
      for (int n = 0; n < NT; n++)
        for (int e = 0; e <= TL + 1; e++) begin
          int es, et;
          if (n == c) continue;
          do_reset();
          step(ta(c), 1, 0, 0);
          if (e == 0) step(ta(n), 1, 1, 0);
          else begin
            step(ta(c), 1, 1, 0);
            for (int k = 1; k < e; k++) step(ta(c), 1, 0, 0);
            step(ta(n), 1, 0, 0);
          end
          chk($sformatf("R1 sweep id c=%0d n=%0d e=%0d", c, n, e), int'(cur_task), n);
          step(8'h80, 1, 0, 0);
          es = (e >= TL ? 1 : 0) + ((e < TCS && n != (c + 1) % NT) ? 1 : 0);
          et = (e >= TCS) ? 1 : 0;
          chk($sformatf("R4 R5 R6 seq c=%0d n=%0d e=%0d", c, n, e), seq_cnt, es);
          chk($sformatf("R7 time c=%0d n=%0d e=%0d", c, n, e), time_cnt, et);
        end

    do_reset();
    step(ta(0), 1, 0, 0);
    step(ta(0), 1, 1, 0);
    for (int k = 1; k < TL; k++) step(ta(0), 1, 0, 0);
    chk("R6 stuck task timeout", seq_cnt, 1);
    step(ta(0), 1, 0, 0);
    step(ta(1), 1, 1, 0);
    step(8'h80, 1, 0, 0);
    chk("R6 missed then next 0,0,1 seq", seq_cnt, 1);
    chk("R6 missed then next 0,0,1 time", time_cnt, 0);

    do_reset();
    step(ta(0), 1, 0, 0);
    step(ta(0), 1, 1, 0);
    for (int k = 1; k < TL; k++) step(ta(0), 1, 0, 0);
    step(ta(2), 1, 1, 0);
    step(8'h80, 1, 0, 0);
    chk("R6 missed then skip 0,0,2 seq", seq_cnt, 2);
    chk("R6 missed then skip 0,0,2 time", time_cnt, 0);

    do_reset();
    step(ta(0), 1, 0, 0);
    step(ta(1), 1, 0, 0);
    chk("R8 pulse cycle one", int'(time_err_pulse), 1);
    chk("R8 flag set with pulse", int'(time_err_flag), 1);
    step(8'h80, 1, 0, 0);
    chk("R8 pulse gone", int'(time_err_pulse), 0);
    for (int k = 0; k < 5; k++) step(8'h80, 1, 0, 0);
    chk("R8 flag sticky", int'(time_err_flag), 1);
    step(8'h80, 1, 0, 1);
    chk("R8 flag cleared", int'(time_err_flag), 0);
    step(ta(2), 1, 0, 1);
    chk("R8 set wins over clear", int'(time_err_flag), 1);
    step(8'h80, 1, 0, 1);
    chk("R8 cleared after collision", int'(time_err_flag), 0);
    chk("R8 seq flag untouched", int'(seq_err_flag), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule